// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

This block is a general-purpose I/O port of 28 lines sitting on a simple 32-bit register bus. Each line has an output latch and a direction control. A line whose direction bit is 1 drives its latch value onto the pad. A line whose direction bit is 0 has its driver off. Software changes latch bits through two write-only ports, one that sets bits and one that clears them, so changing one line never needs a read-modify-write.

Every pad is brought through a two-flop synchronizer. The synchronized level can be read back whatever the line's direction. Each line has its own rising-edge enable and falling-edge enable. A qualifying transition sets a sticky status bit, which stays set until software writes 1 to it.

The status bits of the eleven lowest lines each drive their own interrupt output. The remaining upper lines share one interrupt output, which is the OR of their status bits. A per-line alternate-function select is stored and read back only.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset the output latch, direction, both edge enables, edge status and alternate-function select are all zero, so `pin_oe`, `pin_o`, `irq_line` and `irq_shared` are zero.
- R2: A write to word index 2 (byte offset 0x08) sets every latch bit whose data bit is 1. Latch bits whose data bit is 0 are unchanged.
- R3: A write to word index 3 (byte offset 0x0C) clears every latch bit whose data bit is 1. Latch bits whose data bit is 0 are unchanged.
- R4: The direction register is at word index 1 (byte offset 0x04). `pin_oe` equals the direction register and `pin_o` equals the output latch, both from the edge after the write.
- R5: A read of word index 0 (byte offset 0x00) returns the synchronized pad level of every line, whatever its direction. A pad change becomes visible in the level read two edges after it is sampled. Writes to index 0 have no effect.
- R6: When bit n of the rising enable (index 4, offset 0x10) is 1, a 0-to-1 transition of synchronized line n sets status bit n.
- R7: When bit n of the falling enable (index 5, offset 0x14) is 1, a 1-to-0 transition sets status bit n. With both enables set, either transition sets it. With neither set, transitions leave it unchanged.
- R8: Status (index 6, offset 0x18) is sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R9: If a qualifying edge and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: `irq_line[n]` equals status bit n for lines 0 to 10. `irq_shared` equals the OR of status bits 11 to 27.
- R11: The alternate-function register (index 7, offset 0x1C) reads back what was written. Reads of indices 2 and 3 return zero.
- R12: Register bits 28 to 31 always read as zero. Read data is registered and appears one cycle after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_idx | input | 3 | Register word index (byte offset / 4) |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_i | input | 28 | Pad input levels |
| pin_o | output | 28 | Pad output values (output latch) |
| pin_oe | output | 28 | Pad driver enables (direction) |
| irq_line | output | 11 | Per-line interrupts for lines 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for lines 11 to 27 |

## Verification
The bench builds the block with its default values: 28 lines, 11 dedicated interrupts and a 32-bit data path. With these values the four always-zero bits 28 to 31 are exercised by random full-width writes. So is the boundary where line 10 drives its own interrupt and line 11 falls into the shared one, and the top line 27 is covered. Random pad changes land on mixes of enabled and disabled edges. A directed case times a clear write onto the very edge that sets the same bit.

// File: rtl/edge_gpio_pkg.sv
package edge_gpio_pkg;
  localparam int IDX_W = 3;

  // word index of each register; software-visible order
  typedef enum logic [IDX_W-1:0] {
    IDX_LEVEL = 3'd0,
    IDX_DIR   = 3'd1,
    IDX_SET   = 3'd2,
    IDX_CLR   = 3'd3,
    IDX_RISE  = 3'd4,
    IDX_FALL  = 3'd5,
    IDX_STAT  = 3'd6,
    IDX_ALT   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/egpio_sync.sv
module egpio_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/egpio_edge_cell.sv
module egpio_edge_cell (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr,
  output logic status_q,
  output logic status_nxt
);
  logic prev_q;
  logic rise_hit;
  logic fall_hit;

  always_comb begin
    rise_hit   = smp & ~prev_q & rise_en;
    fall_hit   = ~smp & prev_q & fall_en;
    // a fresh edge overrides a clear in the same cycle
    status_nxt = (status_q & ~clr) | rise_hit | fall_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= smp;
      status_q <= status_nxt;
    end
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (smp && !prev_q && rise_en) |=> status_q); // R6
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
    (!smp && prev_q && fall_en) |=> status_q); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr) |=> status_q); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!status_q && (smp == prev_q)) |=> !status_q); // R7
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (clr && smp && !prev_q && rise_en) |=> status_q); // R9
endmodule

// File: rtl/egpio_regs.sv
module egpio_regs
  import edge_gpio_pkg::*;
#(
  parameter int NUM_LINES = 28,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] level,
  input  logic [NUM_LINES-1:0] status,
  output logic [NUM_LINES-1:0] latch_q,
  output logic [NUM_LINES-1:0] dir_q,
  output logic [NUM_LINES-1:0] rise_en_q,
  output logic [NUM_LINES-1:0] fall_en_q,
  output logic [NUM_LINES-1:0] stat_clr,
  output logic [DATA_W-1:0]    rdata
);
  reg_idx_e               sel;
  logic [NUM_LINES-1:0]   wlines;
  logic [NUM_LINES-1:0]   alt_q;
  logic [NUM_LINES-1:0]   rd_lines;
  logic [DATA_W-1:0]      rd_word;
  logic                   unused_wdata;

  assign sel          = reg_idx_e'(idx);
  assign wlines       = wdata[NUM_LINES-1:0];
  assign unused_wdata = ^wdata;
  assign stat_clr     = (we && sel == IDX_STAT) ? wlines : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      dir_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      alt_q     <= '0;
    end else if (we) begin
      unique case (sel)
        IDX_DIR:  dir_q     <= wlines;
        IDX_SET:  latch_q   <= latch_q | wlines;
        IDX_CLR:  latch_q   <= latch_q & ~wlines;
        IDX_RISE: rise_en_q <= wlines;
        IDX_FALL: fall_en_q <= wlines;
        IDX_ALT:  alt_q     <= wlines;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      IDX_LEVEL: rd_lines = level;
      IDX_DIR:   rd_lines = dir_q;
      IDX_RISE:  rd_lines = rise_en_q;
      IDX_FALL:  rd_lines = fall_en_q;
      IDX_STAT:  rd_lines = status;
      IDX_ALT:   rd_lines = alt_q;
      default:   rd_lines = '0;
    endcase
    rd_word                = '0;
    rd_word[NUM_LINES-1:0] = rd_lines;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

  AST_SET_PORT: assert property (@(posedge clk) disable iff (rst)
    (we && sel == IDX_SET) |=>
      ((latch_q & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0]))); // R2
  AST_CLR_PORT: assert property (@(posedge clk) disable iff (rst)
    (we && sel == IDX_CLR) |=> ((latch_q & $past(wdata[NUM_LINES-1:0])) == '0)); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && sel == IDX_DIR) |=> $stable(dir_q)); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:NUM_LINES] == '0); // R12
endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
  import edge_gpio_pkg::*;
#(
  parameter int NUM_LINES  = 28,
  parameter int NUM_DIRECT = 11,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      bus_idx,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0]  pin_i,
  output logic [NUM_LINES-1:0]  pin_o,
  output logic [NUM_LINES-1:0]  pin_oe,
  output logic [NUM_DIRECT-1:0] irq_line,
  output logic                  irq_shared
);
  localparam int SHARED_LO = NUM_DIRECT;

  logic [NUM_LINES-1:0] level;
  logic [NUM_LINES-1:0] latch_q;
  logic [NUM_LINES-1:0] dir_q;
  logic [NUM_LINES-1:0] rise_en_q;
  logic [NUM_LINES-1:0] fall_en_q;
  logic [NUM_LINES-1:0] stat_clr;
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] status_nxt;

  egpio_sync #(.W(NUM_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (level)
  );

  egpio_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .idx       (bus_idx),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .level     (level),
    .status    (status_q),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .rise_en_q (rise_en_q),
    .fall_en_q (fall_en_q),
    .stat_clr  (stat_clr),
    .rdata     (bus_rdata)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    egpio_edge_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .smp        (level[g]),
      .rise_en    (rise_en_q[g]),
      .fall_en    (fall_en_q[g]),
      .clr        (stat_clr[g]),
      .status_q   (status_q[g]),
      .status_nxt (status_nxt[g])
    );
  end

  // shared interrupt registered from next state so it aligns with status
  always_ff @(posedge clk) begin
    if (rst) irq_shared <= 1'b0;
    else     irq_shared <= |status_nxt[NUM_LINES-1:SHARED_LO];
  end

  assign irq_line = status_q[NUM_DIRECT-1:0];
  assign pin_o    = latch_q;
  assign pin_oe   = dir_q;

  AST_SHARED_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq_shared == (|status_q[NUM_LINES-1:SHARED_LO])); // R10
endmodule

// File: tb/edge_gpio_ctrl_bench.sv
module edge_gpio_ctrl_bench;
  localparam int NL = 28;
  localparam int ND = 11;
  localparam logic [31:0] LMASK = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_idx = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] pin_i = '0;
  logic [NL-1:0] pin_o;
  logic [NL-1:0] pin_oe;
  logic [ND-1:0] irq_line;
  logic          irq_shared;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  // reference model
  logic [31:0] m_latch, m_dir, m_ren, m_fen, m_stat, m_alt, m_pins;

  always #2 clk = ~clk;

  edge_gpio_ctrl u_edge_gpio_ctrl (
    .clk, .rst, .bus_idx, .bus_we, .bus_wdata, .bus_rdata,
    .pin_i, .pin_o, .pin_oe, .irq_line, .irq_shared
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int idx);
    case (idx)
      0: return m_pins & LMASK;
      1: return m_dir;
      4: return m_ren;
      5: return m_fen;
      6: return m_stat;
      7: return m_alt;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_idx = 3'(idx); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    d = d & LMASK;
    case (idx)
      1: m_dir = d;
      2: m_latch = m_latch | d;
      3: m_latch = m_latch & ~d;
      4: m_ren = d;
      5: m_fen = d;
      6: m_stat = m_stat & ~d;
      7: m_alt = d;
      default: ;
    endcase
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_idx = 3'(idx); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive_pins(input logic [31:0] nv);
    logic [31:0] r, f;
    nv = nv & LMASK;
    @(negedge clk);
    pin_i = nv[NL-1:0];
    repeat (3) @(negedge clk);
    r = nv & ~m_pins;
    f = ~nv & m_pins & LMASK;
    m_stat = m_stat | (r & m_ren) | (f & m_fen);
    m_pins = nv;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(i, d);
      case (i)
        0: chk({tag, " R5 level"}, d, exp_read(i));
        1: chk({tag, " R4 dir"}, d, exp_read(i));
        2, 3: chk({tag, " R11 port read zero"}, d, exp_read(i));
        4: chk({tag, " R6 rise en"}, d, exp_read(i));
        5: chk({tag, " R7 fall en"}, d, exp_read(i));
        6: chk({tag, " R8 status R12"}, d, exp_read(i));
        default: chk({tag, " R11 alt"}, d, exp_read(i));
      endcase
    end
    chk({tag, " R4 pin_o"}, 32'(pin_o), m_latch);
    chk({tag, " R4 pin_oe"}, 32'(pin_oe), m_dir);
    chk({tag, " R10 irq_line"}, 32'(irq_line), m_stat & 32'h7FF);
    chk({tag, " R10 irq_shared"}, 32'(irq_shared), 32'(|m_stat[27:11]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_latch = 0; m_dir = 0; m_ren = 0; m_fen = 0; m_stat = 0; m_alt = 0; m_pins = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check_all("reset R1");

    // R2 / R3 directed
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'h0000_0F0F);
    chk("R2 set", 32'(pin_o), 32'h0000_0F0F);
    wr(3, 32'h0000_0F00);
    chk("R3 clear", 32'(pin_o), 32'h0000_000F);
    wr(0, 32'hFFFF_FFFF);
    check_all("R5 level write ignored");

    // R7 both edges on line 10 and line 11 boundary
    wr(4, 32'h0000_0C00);
    wr(5, 32'h0000_0C00);
    drive_pins(32'h0000_0400);
    chk("R7 rise line10 irq", 32'(irq_line[10]), 32'd1);
    chk("R10 shared idle", 32'(irq_shared), 32'd0);
    drive_pins(32'h0000_0800);
    chk("R7 fall line10 / rise line11 shared", 32'(irq_shared), 32'd1);
    wr(6, 32'h0);
    check_all("R8 write zero");

    // R9 race: edge and clear on line 10 in the same cycle
    @(negedge clk);
    pin_i = NL'(32'h0000_0C00);
    @(negedge clk);
    @(negedge clk);
    bus_idx = 3'd6; bus_wdata = 32'h0000_0400; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    m_pins = 32'h0000_0C00;
    rd(6, d);
    chk("R9 edge wins over clear", d & 32'h400, 32'h400);
    wr(6, 32'hFFFF_FFFF);
    m_stat = 0;
    check_all("R8 clear all");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) drive_pins($urandom);
      else wr(int'($urandom_range(0, 7)), $urandom);
      if (it % 6 == 5) check_all("random");
    end
    check_all("final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule